// File: doc/BRIEF.md
# Output-Stationary Systolic Matrix Multiplier

This block multiplies an N×K activation tile by a K×N weight tile on a square grid of N×N unsigned 8-bit multiply-accumulate cells. Each cell keeps one element of the result matrix in a local accumulator.

After a start request the block takes one activation column and one weight row per cycle for K cycles:

- Activations enter at the left edge and move one cell right per cycle.
- Weights enter at the top edge and move one cell down per cycle.
- Internal edge delay lines skew both streams, so the caller presents each operand slice without any offset.

Once the skewed wavefront has reached the far corner, every accumulator holds its finished dot product. The result matrix then leaves through a drain path, one row per cycle at the bottom of the grid.

The drain rotates the accumulator columns: the bottom row wraps into the top row. After the drain every accumulator therefore holds its value again. A following tile either adds onto that value or starts from zero, depending on whether the caller pulses the clear input first. This allows a long reduction to be split across several tiles.

Top module: `os_matmul_array`

## Requirements
- R1: After reset `busy`, `done` and `res_valid` are 0.
- R2: With the accumulators cleared before a tile of depth K, lane c of `res_row` on the drain beat with index r equals the sum over k of A[r][k]·B[k][c], taken modulo 2^AW. Here A[r][k] is the 8-bit lane r of `act_in` and B[k][c] is lane c of `wgt_in`, both in the k-th feed cycle. Lane i occupies bits [i·8 +: 8] of the operand buses and bits [i·AW +: AW] of `res_row`.
- R3: Cycle 0 is the cycle after the rising edge that accepts `start`. Operands are sampled in cycles 0 to K−1. `done` and the first `res_valid` appear in cycle K+2N−1, and `done` is high for that single cycle.
- R4: The drain gives N consecutive `res_valid` beats with `res_idx` N−1, N−2, …, 0 (bottom row first). `busy` is 0 in the cycle after the last beat.
- R5: A tile started without a preceding clear adds its products onto the results of the previous tile.
- R6: `clear` held for a cycle while idle zeroes every accumulator. `clear` while busy has no effect.
- R7: `start` is ignored while `busy` is 1.
- R8: `start` with `k_len` equal to 0 or greater than KMAX is ignored, and `busy` stays 0.
- R9: Operand inputs outside the K feed cycles have no effect on the results.
- R10: A tile of depth KMAX = 16 with every operand at 255 gives 1040400 in every lane, with no wrap.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous active-low reset |
| start | input | 1 | Request a new tile (accepted only when idle) |
| k_len | input | KW | Reduction depth K of the tile, 1..KMAX |
| clear | input | 1 | Zero all accumulators (only when idle) |
| act_in | input | N·8 | Activation column, lane r for grid row r |
| wgt_in | input | N·8 | Weight row, lane c for grid column c |
| busy | output | 1 | Tile in feed, flush or drain |
| done | output | 1 | One-cycle pulse: all results complete, first drain beat |
| res_valid | output | 1 | A result row is present on `res_row` |
| res_idx | output | RW | Row index of the result row on `res_row` |
| res_row | output | N·AW | Result row, lane c for grid column c |

## Verification
Properties are checked on every cycle:

- the drain beats count down from N−1 to 0 without gaps;
- `done` coincides only with the first beat and is never repeated;
- `busy` stays high from acceptance until the last beat;
- an illegal depth never starts a tile.

The bench scenarios cover what a property cannot show:

- the numeric dot products for random and saturated operands;
- the exact K+2N−1 latency;
- accumulation across tiles when no clear is given;
- that start, clear and operand noise arriving mid-tile leave the drained values untouched.

// File: rtl/os_mm_pkg.sv
package os_mm_pkg;

   typedef enum logic [1:0] {
      ST_IDLE  = 2'd0,
      ST_FEED  = 2'd1,
      ST_FLUSH = 2'd2,
      ST_DRAIN = 2'd3
   } os_state_e;

endpackage

// File: rtl/os_mm_skew_line.sv
module os_mm_skew_line #(
   parameter int W     = 8,
   parameter int DEPTH = 1
) (
   input  logic         clk,
   input  logic         rst_n,
   input  logic [W-1:0] din,
   output logic [W-1:0] dout
);

   logic [W-1:0] stage [DEPTH];

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         for (int i = 0; i < DEPTH; i++) stage[i] <= '0;
      end else begin
         stage[0] <= din;
         for (int i = 1; i < DEPTH; i++) stage[i] <= stage[i-1];
      end
   end

   assign dout = stage[DEPTH-1];

endmodule

// File: rtl/os_mm_mac_cell.sv
module os_mm_mac_cell #(
   parameter int DW = 8,
   parameter int AW = 20
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic [DW-1:0] a_op,
   input  logic [DW-1:0] b_op,
   input  logic          acc_clr,
   input  logic          drain_en,
   input  logic [AW-1:0] shift_in,
   output logic [AW-1:0] acc
);

   localparam int PW = 2 * DW;

   logic [PW-1:0] prod;

   assign prod = a_op * b_op;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)        acc <= '0;
      else if (acc_clr)  acc <= '0;
      else if (drain_en) acc <= shift_in;
      else               acc <= acc + AW'(prod);
   end

endmodule

// File: rtl/os_mm_ctrl.sv
module os_mm_ctrl
   import os_mm_pkg::*;
#(
   parameter int N    = 4,
   parameter int KMAX = 16,
   parameter int KW   = 5,
   parameter int RW   = 2
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic          start,
   input  logic [KW-1:0] k_len,
   input  logic          clear,
   output logic          feed_en,
   output logic          drain_en,
   output logic          acc_clr,
   output logic          busy,
   output logic          done,
   output logic [RW-1:0] res_idx
);

   localparam int CW        = $clog2(KMAX + 2 * N + 1);
   localparam int FLUSH_LEN = 2 * N - 1;

   os_state_e     state;
   logic [CW-1:0] cnt;
   logic [KW-1:0] klen_q;
   logic          len_ok;

   assign len_ok = (k_len != '0) && (32'(k_len) <= KMAX);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         state  <= ST_IDLE;
         cnt    <= '0;
         klen_q <= '0;
      end else begin
         unique case (state)
            ST_IDLE: begin
               if (start && len_ok) begin
                  state  <= ST_FEED;
                  cnt    <= '0;
                  klen_q <= k_len;
               end
            end
            ST_FEED: begin
               if (cnt == CW'(klen_q) - CW'(1)) begin
                  state <= ST_FLUSH;
                  cnt   <= '0;
               end else begin
                  cnt <= cnt + CW'(1);
               end
            end
            ST_FLUSH: begin
               if (cnt == CW'(FLUSH_LEN - 1)) begin
                  state <= ST_DRAIN;
                  cnt   <= '0;
               end else begin
                  cnt <= cnt + CW'(1);
               end
            end
            ST_DRAIN: begin
               if (cnt == CW'(N - 1)) begin
                  state <= ST_IDLE;
                  cnt   <= '0;
               end else begin
                  cnt <= cnt + CW'(1);
               end
            end
            default: state <= ST_IDLE;
         endcase
      end
   end

   assign feed_en  = (state == ST_FEED);
   assign drain_en = (state == ST_DRAIN);
   assign acc_clr  = (state == ST_IDLE) && clear;
   assign busy     = (state != ST_IDLE);
   assign done     = drain_en && (cnt == '0);
   assign res_idx  = RW'(N - 1) - cnt[RW-1:0];

endmodule

// File: rtl/os_matmul_array.sv
module os_matmul_array #(
   parameter int N    = 4,
   parameter int DW   = 8,
   parameter int AW   = 20,
   parameter int KMAX = 16,
   parameter int KW   = $clog2(KMAX + 1),
   parameter int RW   = $clog2(N)
) (
   input  logic            clk,
   input  logic            rst_n,
   input  logic            start,
   input  logic [KW-1:0]   k_len,
   input  logic            clear,
   input  logic [N*DW-1:0] act_in,
   input  logic [N*DW-1:0] wgt_in,
   output logic            busy,
   output logic            done,
   output logic            res_valid,
   output logic [RW-1:0]   res_idx,
   output logic [N*AW-1:0] res_row
);

   localparam int GROWTH = $clog2(KMAX);

   if (N < 2) begin : g_chk_n
      $error("os_matmul_array: N must be at least 2");
   end
   if (AW < 2 * DW + GROWTH) begin : g_chk_aw
      $error("os_matmul_array: AW too narrow for KMAX products");
   end
   if (KW < $clog2(KMAX + 1)) begin : g_chk_kw
      $error("os_matmul_array: KW cannot hold KMAX");
   end
   if (RW != $clog2(N)) begin : g_chk_rw
      $error("os_matmul_array: RW must be clog2(N)");
   end

   logic feed_en;
   logic drain_en;
   logic acc_clr;

   os_mm_ctrl #(
      .N(N), .KMAX(KMAX), .KW(KW), .RW(RW)
   ) u_ctrl (
      .clk      (clk),
      .rst_n    (rst_n),
      .start    (start),
      .k_len    (k_len),
      .clear    (clear),
      .feed_en  (feed_en),
      .drain_en (drain_en),
      .acc_clr  (acc_clr),
      .busy     (busy),
      .done     (done),
      .res_idx  (res_idx)
   );

   assign res_valid = drain_en;

   // operand registers seen by each cell
   logic [DW-1:0] a_pipe [N][N];
   logic [DW-1:0] b_pipe [N][N];
   logic [AW-1:0] acc_q  [N][N];

   // left edge: row r delayed r cycles plus the first cell register
   for (genvar r = 0; r < N; r++) begin : g_row_edge
      logic [DW-1:0] a_gated;
      assign a_gated = feed_en ? act_in[r*DW +: DW] : '0;
      os_mm_skew_line #(.W(DW), .DEPTH(r + 1)) u_skew_a (
         .clk  (clk),
         .rst_n(rst_n),
         .din  (a_gated),
         .dout (a_pipe[r][0])
      );
   end

   // top edge: column c delayed c cycles plus the first cell register
   for (genvar c = 0; c < N; c++) begin : g_col_edge
      logic [DW-1:0] b_gated;
      assign b_gated = feed_en ? wgt_in[c*DW +: DW] : '0;
      os_mm_skew_line #(.W(DW), .DEPTH(c + 1)) u_skew_b (
         .clk  (clk),
         .rst_n(rst_n),
         .din  (b_gated),
         .dout (b_pipe[0][c])
      );
   end

   for (genvar r = 0; r < N; r++) begin : g_row
      for (genvar c = 0; c < N; c++) begin : g_col
         if (c > 0) begin : g_a_hop
            always_ff @(posedge clk or negedge rst_n) begin
               if (!rst_n) a_pipe[r][c] <= '0;
               else        a_pipe[r][c] <= a_pipe[r][c-1];
            end
         end
         if (r > 0) begin : g_b_hop
            always_ff @(posedge clk or negedge rst_n) begin
               if (!rst_n) b_pipe[r][c] <= '0;
               else        b_pipe[r][c] <= b_pipe[r-1][c];
            end
         end

         logic [AW-1:0] shift_src;
         if (r == 0) begin : g_wrap
            assign shift_src = acc_q[N-1][c];
         end else begin : g_down
            assign shift_src = acc_q[r-1][c];
         end

         os_mm_mac_cell #(.DW(DW), .AW(AW)) u_cell (
            .clk      (clk),
            .rst_n    (rst_n),
            .a_op     (a_pipe[r][c]),
            .b_op     (b_pipe[r][c]),
            .acc_clr  (acc_clr),
            .drain_en (drain_en),
            .shift_in (shift_src),
            .acc      (acc_q[r][c])
         );
      end
   end

   for (genvar c = 0; c < N; c++) begin : g_out
      assign res_row[c*AW +: AW] = acc_q[N-1][c];
   end

endmodule

// File: rtl/os_matmul_array_chk.sv
module os_matmul_array_chk #(
   parameter int N    = 4,
   parameter int KMAX = 16,
   parameter int KW   = 5,
   parameter int RW   = 2
) (
   input logic          clk,
   input logic          rst_n,
   input logic          start,
   input logic [KW-1:0] k_len,
   input logic          busy,
   input logic          done,
   input logic          res_valid,
   input logic [RW-1:0] res_idx
);

   assert_valid_in_busy_R1: assert property (@(posedge clk) disable iff (!rst_n)
      res_valid |-> busy);

   assert_done_first_beat_R3: assert property (@(posedge clk) disable iff (!rst_n)
      done |-> (res_valid && res_idx == RW'(N - 1)));

   assert_done_single_R3: assert property (@(posedge clk) disable iff (!rst_n)
      done |=> !done);

   assert_drain_countdown_R4: assert property (@(posedge clk) disable iff (!rst_n)
      (res_valid && res_idx != '0) |=> (res_valid && res_idx == $past(res_idx) - RW'(1)));

   assert_drain_ends_R4: assert property (@(posedge clk) disable iff (!rst_n)
      (res_valid && res_idx == '0) |=> !busy);

   assert_busy_holds_R7: assert property (@(posedge clk) disable iff (!rst_n)
      (busy && !res_valid) |=> busy);

   assert_bad_len_ignored_R8: assert property (@(posedge clk) disable iff (!rst_n)
      (!busy && start && (k_len == '0 || 32'(k_len) > KMAX)) |=> !busy);

endmodule

bind os_matmul_array os_matmul_array_chk #(
   .N(N), .KMAX(KMAX), .KW(KW), .RW(RW)
) u_chk (
   .clk      (clk),
   .rst_n    (rst_n),
   .start    (start),
   .k_len    (k_len),
   .busy     (busy),
   .done     (done),
   .res_valid(res_valid),
   .res_idx  (res_idx)
);

// File: tb/os_matmul_array_test.sv
module os_matmul_array_test;

   localparam int N    = 4;
   localparam int DW   = 8;
   localparam int AW   = 20;
   localparam int KMAX = 16;
   localparam int KW   = $clog2(KMAX + 1);
   localparam int RW   = $clog2(N);

   logic            clk = 1'b0;
   logic            rst_n = 1'b0;
   logic            start = 1'b0;
   logic [KW-1:0]   k_len = '0;
   logic            clear = 1'b0;
   logic [N*DW-1:0] act_in = '0;
   logic [N*DW-1:0] wgt_in = '0;
   logic            busy, done, res_valid;
   logic [RW-1:0]   res_idx;
   logic [N*AW-1:0] res_row;

   int total = 0;
   int bad   = 0;

   logic [DW-1:0] opa [N][KMAX];
   logic [DW-1:0] opb [KMAX][N];
   logic [AW-1:0] mdl [N][N];

   always #5 clk = ~clk;

   os_matmul_array #(.N(N), .DW(DW), .AW(AW), .KMAX(KMAX)) uut (
      .clk(clk), .rst_n(rst_n), .start(start), .k_len(k_len), .clear(clear),
      .act_in(act_in), .wgt_in(wgt_in), .busy(busy), .done(done),
      .res_valid(res_valid), .res_idx(res_idx), .res_row(res_row)
   );

   task automatic chk(input bit ok, input string tag, input string what,
                      input longint act, input longint exp);
      total++;
      if (!ok) begin
         bad++;
         $display("FAIL %s %s: actual=%0d expected=%0d", tag, what, act, exp);
      end
   endtask

   task automatic fill_ops(input int k, input int mode);
      for (int i = 0; i < k; i++)
         for (int j = 0; j < N; j++) begin
            opa[j][i] = (mode == 1) ? 8'hFF : DW'($urandom);
            opb[i][j] = (mode == 1) ? 8'hFF : DW'($urandom);
         end
   endtask

   task automatic run_tile(input int k, input bit do_clear, input bit disturb, input string tag);
      if (do_clear) begin
         @(negedge clk) clear = 1'b1;
         @(negedge clk) clear = 1'b0;
         for (int r = 0; r < N; r++)
            for (int c = 0; c < N; c++) mdl[r][c] = '0;
      end
      for (int r = 0; r < N; r++)
         for (int c = 0; c < N; c++)
            for (int i = 0; i < k; i++)
               mdl[r][c] = mdl[r][c] + AW'(opa[r][i] * opb[i][c]);
      @(negedge clk);
      start = 1'b1;
      k_len = KW'(k);
      @(negedge clk);
      start = 1'b0;
      // cycle 0: feed window
      for (int i = 0; i < k; i++) begin
         for (int j = 0; j < N; j++) begin
            act_in[j*DW +: DW] = opa[j][i];
            wgt_in[j*DW +: DW] = opb[i][j];
         end
         if (disturb && i == 0) begin
            start = 1'b1;   // R7: must be ignored
            k_len = KW'(2);
         end else begin
            start = 1'b0;
         end
         @(negedge clk);
      end
      start = 1'b0;
      // R9: noise outside the feed window
      for (int i = 0; i < 2 * N - 1; i++) begin
         act_in = (N*DW)'({$urandom, $urandom});
         wgt_in = (N*DW)'({$urandom, $urandom});
         clear  = disturb && (i == 1);   // R6: ignored while busy
         start  = disturb && (i == 2);   // R7
         chk(done == 1'b0, "R3", "done early", done, 0);
         @(negedge clk);
      end
      clear = 1'b0;
      start = 1'b0;
      chk(done == 1'b1, "R3", "done at K+2N-1", done, 1);
      for (int j = 0; j < N; j++) begin
         chk(res_valid == 1'b1, "R4", "res_valid beat", res_valid, 1);
         chk(res_idx == RW'(N - 1 - j), "R4", "res_idx order", res_idx, N - 1 - j);
         if (j > 0) chk(done == 1'b0, "R3", "done single", done, 0);
         for (int c = 0; c < N; c++)
            chk(res_row[c*AW +: AW] == mdl[N-1-j][c], tag, "result lane",
                res_row[c*AW +: AW], mdl[N-1-j][c]);
         @(negedge clk);
      end
      chk(busy == 1'b0, "R4", "busy after drain", busy, 0);
      chk(res_valid == 1'b0, "R4", "valid after drain", res_valid, 0);
   endtask

   initial begin
      repeat (100000) @(posedge clk);
      bad++;
      total++;
      $display("FAIL watchdog: actual=expired expected=finished");
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
   end

   initial begin
      void'($urandom(32'h5EED_0C1A));
      repeat (3) @(negedge clk);
      chk(busy == 1'b0, "R1", "busy after reset", busy, 0);
      chk(done == 1'b0, "R1", "done after reset", done, 0);
      chk(res_valid == 1'b0, "R1", "valid after reset", res_valid, 0);
      rst_n = 1'b1;
      @(negedge clk);

      fill_ops(4, 0);
      run_tile(4, 1'b1, 1'b0, "R2");
      fill_ops(1, 0);
      run_tile(1, 1'b1, 1'b0, "R2");
      fill_ops(KMAX, 1);
      run_tile(KMAX, 1'b1, 1'b0, "R10");
      chk(mdl[0][0] == AW'(1040400), "R10", "saturated model", mdl[0][0], 1040400);
      fill_ops(7, 0);
      run_tile(7, 1'b0, 1'b0, "R5");
      fill_ops(5, 0);
      run_tile(5, 1'b1, 1'b1, "R6");

      // R8: illegal depths
      @(negedge clk) begin start = 1'b1; k_len = '0; end
      @(negedge clk) start = 1'b0;
      chk(busy == 1'b0, "R8", "k_len=0 ignored", busy, 0);
      @(negedge clk) begin start = 1'b1; k_len = KW'(KMAX + 1); end
      @(negedge clk) start = 1'b0;
      chk(busy == 1'b0, "R8", "k_len>KMAX ignored", busy, 0);

      for (int t = 0; t < 6; t++) begin
         int k;
         k = 1 + int'($urandom % KMAX);
         fill_ops(k, 0);
         run_tile(k, (t % 3) != 2, t == 4, "R2");
      end

      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
   end

endmodule